// File: doc/BRIEF.md
# Pipelined Dual-Port Synchronous RAM

This block is a word-wide static memory reached through two separate ports, each running on its own clock. Every port captures its address, write strobe, write data and select pins in input registers on the rising clock edge. On the next rising edge it performs the access and loads the read word into an output register. A read therefore shows on the data output one clock after its address was taken in. Both ports may read any word in the same cycle, and one port may write a word while the other reads it. The reader then gets the contents from before the write.

Each port has two select pins, one active high and one active low. A cycle taken in with either pin inactive puts the port to sleep. Its data output is forced to zero, its valid flag stays low and its writes are dropped. The first selected cycle after sleep only wakes the port: that cycle's operation is discarded, and normal accesses resume on the cycle after it. After reset the contents are all zero and both ports start asleep. The value left by two writes to one word in the same cycle is not defined. Such a pair raises a collision flag, aligned with the access results and clocked by port A. For that comparison both ports are assumed to run from related clocks.

Top module: `dpram_top`

## Requirements
- R1: While rst_ni is low, every data output and valid flag and coll_o are zero. Reset clears all words to zero and leaves both ports asleep.
- R2: A selected read taken in at rising edge k, on an awake port, drives the word onto the data output with valid high after rising edge k+1.
- R3: Both ports can read the same word, or different words, in the same cycle, and each gets the correct contents.
- R4: When one port writes a word and the other reads that word in the same cycle, the reader gets the old contents. The following read gets the new contents.
- R5: The write strobe is sampled at the edge, and each selected write cycle stores that cycle's data. The result of a write cycle has valid low and data zero.
- R6: A port is selected only when its active-high select is 1 and its active-low select is 0. A cycle taken in unselected gives data zero and valid low one cycle later, and any write in it is ignored.
- R7: The first selected cycle after a sleep, or after reset, is a wake cycle. Its result has valid low, its write is ignored, and the cycle after it operates normally.
- R8: coll_o goes high, aligned with the results, exactly when both ports perform active writes to the same address in the same cycle.
- R9: Simultaneous writes from the two ports to different addresses are both stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk_i | input | 1 | Port A clock |
| b_clk_i | input | 1 | Port B clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_cs_i | input | 1 | Port A select, active high |
| a_cs_ni | input | 1 | Port A select, active low |
| a_we_i | input | 1 | Port A write strobe (1 = write) |
| a_addr_i | input | AW | Port A word address |
| a_din_i | input | DW | Port A write data |
| a_dout_o | output | DW | Port A read data |
| a_valid_o | output | 1 | Port A read data valid |
| b_cs_i | input | 1 | Port B select, active high |
| b_cs_ni | input | 1 | Port B select, active low |
| b_we_i | input | 1 | Port B write strobe (1 = write) |
| b_addr_i | input | AW | Port B word address |
| b_din_i | input | DW | Port B write data |
| b_dout_o | output | DW | Port B read data |
| b_valid_o | output | 1 | Port B read data valid |
| coll_o | output | 1 | Same-address dual-write flag |

## Verification
The bench aims at a write on one port meeting a read of the same word on the other. A design that forwards the new data returns it one cycle early there. It drives sleep through each select pin and then wakes the port. A design that skips the wake cycle shows valid data a cycle too soon, and one that lets writes through in sleep or in the wake cycle corrupts a word that is read back later. It also covers collision and non-collision write pairs and the top address. It pulses reset in the middle of a run, where a design that does not clear the array returns stale words.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
  localparam int unsigned NPORT = 2;

  // state of the cycle held in the input registers
  typedef enum logic [1:0] {
    PWR_OFF  = 2'd0,
    PWR_WAKE = 2'd1,
    PWR_ON   = 2'd2
  } pwr_e;

  function automatic logic sel_on(input logic cs, input logic cs_n);
    return cs & ~cs_n;
  endfunction
endpackage

// File: rtl/dpram_port_in.sv
module dpram_port_in
  import dpram_pkg::*;
#(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          cs_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] din_i,
  output logic          act_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] din_o
);
  pwr_e          pwr_q;
  logic          we_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] din_q;
  logic          on;

  assign on = sel_on(cs_i, cs_ni);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwr_q  <= PWR_OFF;
      we_q   <= 1'b0;
      addr_q <= '0;
      din_q  <= '0;
    end else begin
      if (!on)                  pwr_q <= PWR_OFF;
      else if (pwr_q == PWR_OFF) pwr_q <= PWR_WAKE;
      else                       pwr_q <= PWR_ON;
      // unselected cycles leave the capture path idle
      we_q <= on & we_i;
      if (on) begin
        addr_q <= addr_i;
        din_q  <= din_i;
      end
    end
  end

  assign act_o  = (pwr_q == PWR_ON);
  assign we_o   = we_q;
  assign addr_o = addr_q;
  assign din_o  = din_q;
endmodule

// File: rtl/dpram_bank.sv
module dpram_bank #(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 16,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [AW-1:0]             addr_i,
  input  logic [DW-1:0]             data_i,
  output logic [DEPTH-1:0][DW-1:0]  mem_o
);
  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    logic [DW-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        word_q <= '0;
      else if (we_i && addr_i == AW'(w))  word_q <= data_i;
    end
    assign mem_o[w] = word_q;
  end
endmodule

// File: rtl/dpram_rd_stage.sv
module dpram_rd_stage #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  logic [DW-1:0] word_i,
  output logic [DW-1:0] dout_o,
  output logic          valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      dout_o  <= rd_i ? word_i : '0;
      valid_o <= rd_i;
    end
  end
endmodule

// File: rtl/dpram_coll.sv
module dpram_coll #(
  parameter int unsigned AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          a_wr_i,
  input  logic [AW-1:0] a_addr_i,
  input  logic          b_wr_i,
  input  logic [AW-1:0] b_addr_i,
  output logic          coll_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) coll_o <= 1'b0;
    else         coll_o <= a_wr_i & b_wr_i & (a_addr_i == b_addr_i);
  end
endmodule

// File: rtl/dpram_top.sv
module dpram_top
  import dpram_pkg::*;
#(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 16
) (
  input  logic          a_clk_i,
  input  logic          b_clk_i,
  input  logic          rst_ni,
  input  logic          a_cs_i,
  input  logic          a_cs_ni,
  input  logic          a_we_i,
  input  logic [AW-1:0] a_addr_i,
  input  logic [DW-1:0] a_din_i,
  output logic [DW-1:0] a_dout_o,
  output logic          a_valid_o,
  input  logic          b_cs_i,
  input  logic          b_cs_ni,
  input  logic          b_we_i,
  input  logic [AW-1:0] b_addr_i,
  input  logic [DW-1:0] b_din_i,
  output logic [DW-1:0] b_dout_o,
  output logic          b_valid_o,
  output logic          coll_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic                     clk    [NPORT];
  logic                     cs     [NPORT];
  logic                     cs_n   [NPORT];
  logic                     we_in  [NPORT];
  logic [AW-1:0]            addr_in[NPORT];
  logic [DW-1:0]            din_in [NPORT];
  logic                     act    [NPORT];
  logic                     we_q   [NPORT];
  logic [AW-1:0]            addr_q [NPORT];
  logic [DW-1:0]            din_q  [NPORT];
  logic                     wr     [NPORT];
  logic [DW-1:0]            wdata  [NPORT];
  logic [DW-1:0]            rword  [NPORT];
  logic [DW-1:0]            dout   [NPORT];
  logic                     valid  [NPORT];
  logic [DEPTH-1:0][DW-1:0] bank_mem[NPORT];

  assign clk[0] = a_clk_i;   assign clk[1] = b_clk_i;
  assign cs[0] = a_cs_i;     assign cs[1] = b_cs_i;
  assign cs_n[0] = a_cs_ni;  assign cs_n[1] = b_cs_ni;
  assign we_in[0] = a_we_i;  assign we_in[1] = b_we_i;
  assign addr_in[0] = a_addr_i; assign addr_in[1] = b_addr_i;
  assign din_in[0] = a_din_i;   assign din_in[1] = b_din_i;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dpram_port_in #(.AW(AW), .DW(DW)) u_in (
      .clk_i (clk[p]),
      .rst_ni(rst_ni),
      .cs_i  (cs[p]),
      .cs_ni (cs_n[p]),
      .we_i  (we_in[p]),
      .addr_i(addr_in[p]),
      .din_i (din_in[p]),
      .act_o (act[p]),
      .we_o  (we_q[p]),
      .addr_o(addr_q[p]),
      .din_o (din_q[p])
    );

    assign wr[p] = act[p] & we_q[p];
    // each port owns one bank; stored word is the xor of both banks
    assign wdata[p] = din_q[p] ^ bank_mem[NPORT-1-p][addr_q[p]];
    assign rword[p] = bank_mem[0][addr_q[p]] ^ bank_mem[1][addr_q[p]];

    dpram_bank #(.AW(AW), .DW(DW)) u_bank (
      .clk_i (clk[p]),
      .rst_ni(rst_ni),
      .we_i  (wr[p]),
      .addr_i(addr_q[p]),
      .data_i(wdata[p]),
      .mem_o (bank_mem[p])
    );

    dpram_rd_stage #(.DW(DW)) u_rd (
      .clk_i  (clk[p]),
      .rst_ni (rst_ni),
      .rd_i   (act[p] & ~we_q[p]),
      .word_i (rword[p]),
      .dout_o (dout[p]),
      .valid_o(valid[p])
    );
  end

  dpram_coll #(.AW(AW)) u_coll (
    .clk_i   (a_clk_i),
    .rst_ni  (rst_ni),
    .a_wr_i  (wr[0]),
    .a_addr_i(addr_q[0]),
    .b_wr_i  (wr[1]),
    .b_addr_i(addr_q[1]),
    .coll_o  (coll_o)
  );

  assign a_dout_o  = dout[0];
  assign a_valid_o = valid[0];
  assign b_dout_o  = dout[1];
  assign b_valid_o = valid[1];
endmodule

// File: rtl/dpram_chk.sv
module dpram_chk #(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 16
) (
  input logic          a_clk_i,
  input logic          b_clk_i,
  input logic          rst_ni,
  input logic          a_cs_i,
  input logic          a_cs_ni,
  input logic          a_we_i,
  input logic [AW-1:0] a_addr_i,
  input logic [DW-1:0] a_dout_o,
  input logic          a_valid_o,
  input logic          b_cs_i,
  input logic          b_cs_ni,
  input logic          b_we_i,
  input logic [AW-1:0] b_addr_i,
  input logic [DW-1:0] b_dout_o,
  input logic          b_valid_o,
  input logic          coll_o
);
  logic a_on, b_on;
  assign a_on = a_cs_i & ~a_cs_ni;
  assign b_on = b_cs_i & ~b_cs_ni;

  p_pd_quiet_a_r6: assert property (@(posedge a_clk_i) disable iff (!rst_ni)
    !a_on |=> ##1 (!a_valid_o && a_dout_o == '0));

  p_pd_quiet_b_r6: assert property (@(posedge b_clk_i) disable iff (!rst_ni)
    !b_on |=> ##1 (!b_valid_o && b_dout_o == '0));

  p_valid_src_a_r2: assert property (@(posedge a_clk_i) disable iff (!rst_ni)
    a_valid_o |-> $past(a_on && !a_we_i, 2));

  p_valid_src_b_r2: assert property (@(posedge b_clk_i) disable iff (!rst_ni)
    b_valid_o |-> $past(b_on && !b_we_i, 2));

  p_wake_a_r7: assert property (@(posedge a_clk_i) disable iff (!rst_ni)
    (a_on && !$past(a_on)) |=> ##1 !a_valid_o);

  p_wr_quiet_a_r5: assert property (@(posedge a_clk_i) disable iff (!rst_ni)
    (a_on && a_we_i) |=> ##1 (!a_valid_o && a_dout_o == '0));

  p_coll_src_r8: assert property (@(posedge a_clk_i) disable iff (!rst_ni)
    coll_o |-> $past(a_on && a_we_i && b_on && b_we_i && a_addr_i == b_addr_i, 2));
endmodule

bind dpram_top dpram_chk #(.AW(AW), .DW(DW)) u_chk (
  .a_clk_i  (a_clk_i),
  .b_clk_i  (b_clk_i),
  .rst_ni   (rst_ni),
  .a_cs_i   (a_cs_i),
  .a_cs_ni  (a_cs_ni),
  .a_we_i   (a_we_i),
  .a_addr_i (a_addr_i),
  .a_dout_o (a_dout_o),
  .a_valid_o(a_valid_o),
  .b_cs_i   (b_cs_i),
  .b_cs_ni  (b_cs_ni),
  .b_we_i   (b_we_i),
  .b_addr_i (b_addr_i),
  .b_dout_o (b_dout_o),
  .b_valid_o(b_valid_o),
  .coll_o   (coll_o)
);

// File: tb/dpram_top_tb_top.sv
module dpram_top_tb_top;
  localparam int PERIOD = 10;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int NV = 16;

  typedef struct packed {
    logic ae; logic aw; logic [5:0] aa; logic [15:0] ad;
    logic be; logic bw; logic [5:0] ba; logic [15:0] bd;
    logic eav; logic [15:0] ead;
    logic ebv; logic [15:0] ebd;
    logic ec;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,6'd0, 16'h0000, 1'b1,1'b0,6'd0, 16'h0000, 1'b0,16'h0000, 1'b0,16'h0000, 1'b0},
    '{1'b1,1'b1,6'd5, 16'h1111, 1'b1,1'b0,6'd5, 16'h0000, 1'b0,16'h0000, 1'b1,16'h0000, 1'b0},
    '{1'b1,1'b0,6'd5, 16'h0000, 1'b1,1'b0,6'd5, 16'h0000, 1'b1,16'h1111, 1'b1,16'h1111, 1'b0},
    '{1'b1,1'b0,6'd9, 16'h0000, 1'b1,1'b1,6'd9, 16'hBEEF, 1'b1,16'h0000, 1'b0,16'h0000, 1'b0},
    '{1'b1,1'b0,6'd9, 16'h0000, 1'b1,1'b0,6'd5, 16'h0000, 1'b1,16'hBEEF, 1'b1,16'h1111, 1'b0},
    '{1'b1,1'b1,6'd12,16'hAAAA, 1'b1,1'b1,6'd12,16'h5555, 1'b0,16'h0000, 1'b0,16'h0000, 1'b1},
    '{1'b1,1'b1,6'd3, 16'h0303, 1'b1,1'b1,6'd4, 16'h0404, 1'b0,16'h0000, 1'b0,16'h0000, 1'b0},
    '{1'b1,1'b0,6'd3, 16'h0000, 1'b1,1'b0,6'd4, 16'h0000, 1'b1,16'h0303, 1'b1,16'h0404, 1'b0},
    '{1'b1,1'b0,6'd4, 16'h0000, 1'b1,1'b0,6'd3, 16'h0000, 1'b1,16'h0404, 1'b1,16'h0303, 1'b0},
    '{1'b0,1'b1,6'd3, 16'hFFFF, 1'b1,1'b0,6'd3, 16'h0000, 1'b0,16'h0000, 1'b1,16'h0303, 1'b0},
    '{1'b1,1'b0,6'd3, 16'h0000, 1'b1,1'b0,6'd3, 16'h0000, 1'b0,16'h0000, 1'b1,16'h0303, 1'b0},
    '{1'b1,1'b0,6'd3, 16'h0000, 1'b1,1'b1,6'd3, 16'h3333, 1'b1,16'h0303, 1'b0,16'h0000, 1'b0},
    '{1'b1,1'b0,6'd3, 16'h0000, 1'b1,1'b0,6'd63,16'h0000, 1'b1,16'h3333, 1'b1,16'h0000, 1'b0},
    '{1'b1,1'b1,6'd63,16'h7E7E, 1'b0,1'b0,6'd63,16'h0000, 1'b0,16'h0000, 1'b0,16'h0000, 1'b0},
    '{1'b1,1'b0,6'd63,16'h0000, 1'b1,1'b0,6'd63,16'h0000, 1'b1,16'h7E7E, 1'b0,16'h0000, 1'b0},
    '{1'b1,1'b0,6'd63,16'h0000, 1'b1,1'b0,6'd63,16'h0000, 1'b1,16'h7E7E, 1'b1,16'h7E7E, 1'b0}
  };

  localparam string TAGS [NV] = '{
    "R7", "R4", "R3", "R4", "R2", "R8", "R9", "R9",
    "R3", "R6", "R7", "R4", "R5", "R6", "R7", "R3"
  };

  logic clk = 1'b0;
  logic rst_ni;
  logic a_cs, a_csn, a_we, b_cs, b_csn, b_we;
  logic [AW-1:0] a_addr, b_addr;
  logic [DW-1:0] a_din, b_din, a_dout, b_dout;
  logic a_valid, b_valid, coll;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  dpram_top #(.AW(AW), .DW(DW)) dut_i (
    .a_clk_i(clk), .b_clk_i(clk), .rst_ni(rst_ni),
    .a_cs_i(a_cs), .a_cs_ni(a_csn), .a_we_i(a_we), .a_addr_i(a_addr), .a_din_i(a_din),
    .a_dout_o(a_dout), .a_valid_o(a_valid),
    .b_cs_i(b_cs), .b_cs_ni(b_csn), .b_we_i(b_we), .b_addr_i(b_addr), .b_din_i(b_din),
    .b_dout_o(b_dout), .b_valid_o(b_valid),
    .coll_o(coll)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic set_a(input logic cs, input logic csn, input logic we,
                       input logic [AW-1:0] ad, input logic [DW-1:0] d);
    a_cs = cs; a_csn = csn; a_we = we; a_addr = ad; a_din = d;
  endtask

  task automatic set_b(input logic cs, input logic csn, input logic we,
                       input logic [AW-1:0] ad, input logic [DW-1:0] d);
    b_cs = cs; b_csn = csn; b_we = we; b_addr = ad; b_din = d;
  endtask

  initial begin
    #(PERIOD*5000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    set_a(1'b0, 1'b1, 1'b0, '0, '0);
    set_b(1'b0, 1'b1, 1'b0, '0, '0);
    repeat (3) @(negedge clk);
    chk("R1", "reset a_valid", 32'(a_valid), 0);
    chk("R1", "reset a_dout", 32'(a_dout), 0);
    chk("R1", "reset b_valid", 32'(b_valid), 0);
    chk("R1", "reset b_dout", 32'(b_dout), 0);
    chk("R1", "reset coll", 32'(coll), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // table: results of row i appear two falling edges after it is driven
    for (int i = 0; i < NV + 2; i++) begin
      if (i >= 2) begin
        chk(TAGS[i-2], $sformatf("row %0d a_valid", i-2), 32'(a_valid), 32'(VECS[i-2].eav));
        chk(TAGS[i-2], $sformatf("row %0d a_dout", i-2), 32'(a_dout), 32'(VECS[i-2].ead));
        chk(TAGS[i-2], $sformatf("row %0d b_valid", i-2), 32'(b_valid), 32'(VECS[i-2].ebv));
        chk(TAGS[i-2], $sformatf("row %0d b_dout", i-2), 32'(b_dout), 32'(VECS[i-2].ebd));
        chk(TAGS[i-2], $sformatf("row %0d coll", i-2), 32'(coll), 32'(VECS[i-2].ec));
      end
      if (i < NV) begin
        set_a(VECS[i].ae, 1'b0, VECS[i].aw, VECS[i].aa, VECS[i].ad);
        set_b(VECS[i].be, 1'b0, VECS[i].bw, VECS[i].ba, VECS[i].bd);
      end else begin
        set_a(1'b1, 1'b0, 1'b0, '0, '0);
        set_b(1'b1, 1'b0, 1'b0, '0, '0);
      end
      @(negedge clk);
    end

    // R6 through the active-low select, then R7 wake-cycle write dropped
    set_a(1'b1, 1'b1, 1'b0, 6'd3, '0);
    @(negedge clk);
    set_a(1'b1, 1'b0, 1'b1, 6'd20, 16'h1234);
    @(negedge clk);
    chk("R6", "cs_ni sleep a_valid", 32'(a_valid), 0);
    chk("R6", "cs_ni sleep a_dout", 32'(a_dout), 0);
    set_a(1'b1, 1'b0, 1'b0, 6'd20, '0);
    @(negedge clk);
    chk("R7", "wake write a_valid", 32'(a_valid), 0);
    @(negedge clk);
    chk("R7", "wake write dropped valid", 32'(a_valid), 1);
    chk("R7", "wake write dropped dout", 32'(a_dout), 0);

    // R5: back-to-back writes to one word, last one wins
    set_a(1'b1, 1'b0, 1'b1, 6'd21, 16'h00AA);
    @(negedge clk);
    set_a(1'b1, 1'b0, 1'b1, 6'd21, 16'h00BB);
    @(negedge clk);
    set_a(1'b1, 1'b0, 1'b0, 6'd21, '0);
    @(negedge clk);
    chk("R5", "second write a_valid", 32'(a_valid), 0);
    @(negedge clk);
    chk("R5", "last write stored", 32'(a_dout), 32'h00BB);

    // R1: mid-run reset clears outputs and contents
    #1 rst_ni = 1'b0;
    #1;
    chk("R1", "async reset a_valid", 32'(a_valid), 0);
    chk("R1", "async reset b_valid", 32'(b_valid), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    set_a(1'b1, 1'b0, 1'b0, 6'd3, '0);
    @(negedge clk);
    @(negedge clk);
    chk("R1", "post reset wake a_valid", 32'(a_valid), 0);
    @(negedge clk);
    chk("R1", "post reset cleared valid", 32'(a_valid), 1);
    chk("R1", "post reset cleared dout", 32'(a_dout), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule